// File: doc/BRIEF.md
# Reference Clock Frequency-Lock Monitor

This block checks that a reference clock runs at the expected fraction of a locally synthesized word clock. The word clock is the serial clock divided by four. A Gray-coded counter runs on the word clock and is carried into the reference domain through a synchronizer. Over a fixed window of reference-clock edges, the block measures how many word-clock edges occurred. It then compares that count with the count the selected ratio predicts, and turns the difference into a deviation in parts per million.

The single output `in_lock` is high when the two clocks agree and low when they do not. Two thresholds give the output hysteresis. A deviation above the wide limit clears the flag. Only a deviation below the narrow limit sets it again. A deviation between the two limits leaves the flag as it was. A two-bit select picks one of four reference-to-word-clock rate ratios. The select is meant to be static and is changed only while reset is applied.

Top module: `refclk_lock_monitor`

## Requirements
- R1: While `rst_n` is low, `in_lock` is 0. After release, the first window only records a baseline count and issues no verdict, so `in_lock` stays 0 at least until the end of the second window.
- R2: A window is 2^WIN_LOG2 rising edges of `ref_clk`, counted from reset release. `in_lock` can change only on the edge that closes a window.
- R3: `ratio_sel` sets the expected word-clock count per window E, as follows:
  - 0: the reference runs at the word rate, so E = 2^WIN_LOG2.
  - 1: the reference runs at 1/4 of the word rate, so E = 2^(WIN_LOG2+2).
  - 2: the reference runs at 1/8 of the word rate, so E = 2^(WIN_LOG2+3).
  - 3: the reference runs at 1/16 of the word rate, so E = 2^(WIN_LOG2+4).
- R4: With D = |measured count − E|, a window with D > floor(PPM_LOSS·E/10^6) drives `in_lock` to 0.
- R5: A window with D ≤ floor((PPM_LOCK·E − 1)/10^6), which means D·10^6 < PPM_LOCK·E, drives `in_lock` to 1.
- R6: A window whose D lies between the two limits leaves `in_lock` unchanged, whether it was 0 or 1.
- R7: The deviation test is symmetric. A reference that is too fast and one that is too slow by the same amount give the same verdict.
- R8: If the word clock stops for a whole window, the count falls short by about E, and `in_lock` goes to 0. Once the word clock runs again at the right rate, the flag returns to 1.
- R9: The word-clock count crosses into the reference domain in Gray code. Its encoded value changes by at most one bit per word-clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Reference clock; it times the measurement window and the output |
| word_clk | input | 1 | Synthesized word clock (serial clock / 4) |
| rst_n | input | 1 | Asynchronous active-low reset for both clock domains |
| ratio_sel | input | 2 | Reference-to-word-clock rate ratio select (encoding in R3) |
| in_lock | output | 1 | 1 = frequencies agree; 0 = loss of lock |

## Verification
The bench targets the hysteresis band. It drives a deviation between the two limits once while the flag is high and once while it is low. A design that compared against a single threshold would set or clear the flag in one of those two cases. Deviations of both signs are applied, so a design that treats a fast reference as a negative and harmless difference would keep the flag high when it should drop. The bench also stops the word clock for a whole window, where a broken counter crossing would report a stale count. Each of the four ratio settings is checked with a matched and a mismatched reference, so a wrong shift per setting shows up as a false loss of lock or a missed one.

// File: rtl/fmon_pkg.sv
package fmon_pkg;

   localparam longint PPM_SCALE = 64'd1000000;

   // word-clock edges per reference edge, as a power of two, per select code
   function automatic int ratio_shift(input int sel);
      case (sel)
         0:       return 0;
         1:       return 2;
         2:       return 3;
         default: return 4;
      endcase
   endfunction

   function automatic longint expect_count(input int win_log2, input int sel);
      return longint'(1) << (win_log2 + ratio_shift(sel));
   endfunction

   // largest deviation still tolerated before loss is declared
   function automatic longint loss_limit(input int win_log2, input int sel, input int ppm);
      return (longint'(ppm) * expect_count(win_log2, sel)) / PPM_SCALE;
   endfunction

   // largest deviation strictly below the lock threshold
   function automatic longint lock_limit(input int win_log2, input int sel, input int ppm);
      return (longint'(ppm) * expect_count(win_log2, sel) - 1) / PPM_SCALE;
   endfunction

endpackage

// File: rtl/fmon_word_counter.sv
module fmon_word_counter #(
   parameter int CW = 22
) (
   input  logic          word_clk,
   input  logic          rst_n,
   output logic [CW-1:0] gray_o
);
   logic [CW-1:0] bin_q;
   logic [CW-1:0] gray_q;
   logic [CW-1:0] bin_nx;

   assign bin_nx = bin_q + 1'b1;

   always_ff @(posedge word_clk or negedge rst_n) begin
      if (!rst_n) begin
         bin_q  <= '0;
         gray_q <= '0;
      end else begin
         bin_q  <= bin_nx;
         gray_q <= bin_nx ^ (bin_nx >> 1);
      end
   end

   assign gray_o = gray_q;

   assert_gray_one_bit_R9: assert property (@(posedge word_clk) disable iff (!rst_n)
      $countones(gray_q ^ $past(gray_q)) <= 1);

endmodule

// File: rtl/fmon_gray_capture.sv
module fmon_gray_capture #(
   parameter int CW          = 22,
   parameter int SYNC_STAGES = 2
) (
   input  logic          ref_clk,
   input  logic          rst_n,
   input  logic [CW-1:0] gray_i,
   output logic [CW-1:0] count_o
);
   logic [CW-1:0] stage_q [SYNC_STAGES];

   function automatic logic [CW-1:0] gray_decode(input logic [CW-1:0] g);
      logic [CW-1:0] b;
      b[CW-1] = g[CW-1];
      for (int i = CW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
      return b;
   endfunction

   always_ff @(posedge ref_clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < SYNC_STAGES; i++) stage_q[i] <= '0;
      end else begin
         stage_q[0] <= gray_i;
         for (int i = 1; i < SYNC_STAGES; i++) stage_q[i] <= stage_q[i-1];
      end
   end

   assign count_o = gray_decode(stage_q[SYNC_STAGES-1]);

endmodule

// File: rtl/fmon_window_eval.sv
module fmon_window_eval #(
   parameter int WIN_LOG2 = 16,
   parameter int PPM_LOSS = 500,
   parameter int PPM_LOCK = 250,
   parameter int CW       = WIN_LOG2 + 6
) (
   input  logic          ref_clk,
   input  logic          rst_n,
   input  logic [1:0]    ratio_sel,
   input  logic [CW-1:0] count_i,
   output logic          eval_o,
   output logic          too_far_o,
   output logic          close_o,
   output logic          base_o
);
   localparam int NSEL = 4;

   logic [CW-1:0] exp_tab  [NSEL];
   logic [CW-1:0] loss_tab [NSEL];
   logic [CW-1:0] lock_tab [NSEL];

   for (genvar g = 0; g < NSEL; g++) begin : g_ratio
      localparam longint EXPC = fmon_pkg::expect_count(WIN_LOG2, g);
      localparam longint LOSC = fmon_pkg::loss_limit(WIN_LOG2, g, PPM_LOSS);
      localparam longint LOKC = fmon_pkg::lock_limit(WIN_LOG2, g, PPM_LOCK);
      assign exp_tab[g]  = CW'(EXPC);
      assign loss_tab[g] = CW'(LOSC);
      assign lock_tab[g] = CW'(LOKC);
   end

   logic [WIN_LOG2-1:0] win_q;
   logic [CW-1:0]       cap_q;
   logic                base_q;
   logic                at_end;
   logic [CW-1:0]       delta;
   logic [CW:0]         diff;
   logic [CW-1:0]       mag;

   assign at_end = &win_q;
   assign delta  = count_i - cap_q;
   assign diff   = {1'b0, delta} - {1'b0, exp_tab[ratio_sel]};
   assign mag    = diff[CW] ? (~diff[CW-1:0] + 1'b1) : diff[CW-1:0];

   always_ff @(posedge ref_clk or negedge rst_n) begin
      if (!rst_n) begin
         win_q  <= '0;
         cap_q  <= '0;
         base_q <= 1'b0;
      end else begin
         win_q <= win_q + 1'b1;
         if (at_end) begin
            cap_q  <= count_i;
            base_q <= 1'b1;
         end
      end
   end

   assign eval_o    = at_end & base_q;
   assign too_far_o = mag > loss_tab[ratio_sel];
   assign close_o   = mag <= lock_tab[ratio_sel];
   assign base_o    = base_q;

   assert_limits_disjoint_R6: assert property (@(posedge ref_clk) disable iff (!rst_n)
      !(too_far_o && close_o));

endmodule

// File: rtl/fmon_lock_hyst.sv
module fmon_lock_hyst (
   input  logic ref_clk,
   input  logic rst_n,
   input  logic eval_i,
   input  logic too_far_i,
   input  logic close_i,
   output logic lock_o
);
   logic lock_q;

   always_ff @(posedge ref_clk or negedge rst_n) begin
      if (!rst_n)                lock_q <= 1'b0;
      else if (eval_i) begin
         if (too_far_i)          lock_q <= 1'b0;
         else if (close_i)       lock_q <= 1'b1;
      end
   end

   assign lock_o = lock_q;

   assert_band_holds_R6: assert property (@(posedge ref_clk) disable iff (!rst_n)
      (eval_i && !too_far_i && !close_i) |=> $stable(lock_q));

endmodule

// File: rtl/refclk_lock_monitor.sv
module refclk_lock_monitor #(
   parameter int WIN_LOG2    = 16,
   parameter int PPM_LOSS    = 500,
   parameter int PPM_LOCK    = 250,
   parameter int SYNC_STAGES = 2
) (
   input  logic       ref_clk,
   input  logic       word_clk,
   input  logic       rst_n,
   input  logic [1:0] ratio_sel,
   output logic       in_lock
);
   localparam int CW = WIN_LOG2 + 6;

   if (WIN_LOG2 < 4) begin : g_bad_window
      $error("WIN_LOG2 must be at least 4");
   end
   if (PPM_LOCK < 1 || PPM_LOCK >= PPM_LOSS || PPM_LOSS >= 1000000) begin : g_bad_ppm
      $error("thresholds must satisfy 1 <= PPM_LOCK < PPM_LOSS < 1e6");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [CW-1:0] gray_w;
   logic [CW-1:0] count_r;
   logic          eval_r;
   logic          too_far_r;
   logic          close_r;
   logic          base_r;

   fmon_word_counter #(.CW(CW)) u_wcnt (
      .word_clk (word_clk),
      .rst_n    (rst_n),
      .gray_o   (gray_w)
   );

   fmon_gray_capture #(.CW(CW), .SYNC_STAGES(SYNC_STAGES)) u_cap (
      .ref_clk (ref_clk),
      .rst_n   (rst_n),
      .gray_i  (gray_w),
      .count_o (count_r)
   );

   fmon_window_eval #(
      .WIN_LOG2 (WIN_LOG2),
      .PPM_LOSS (PPM_LOSS),
      .PPM_LOCK (PPM_LOCK),
      .CW       (CW)
   ) u_eval (
      .ref_clk   (ref_clk),
      .rst_n     (rst_n),
      .ratio_sel (ratio_sel),
      .count_i   (count_r),
      .eval_o    (eval_r),
      .too_far_o (too_far_r),
      .close_o   (close_r),
      .base_o    (base_r)
   );

   fmon_lock_hyst u_hyst (
      .ref_clk   (ref_clk),
      .rst_n     (rst_n),
      .eval_i    (eval_r),
      .too_far_i (too_far_r),
      .close_i   (close_r),
      .lock_o    (in_lock)
   );

   assert_no_lock_before_base_R1: assert property (@(posedge ref_clk) disable iff (!rst_n)
      !base_r |-> !in_lock);

   assert_change_only_at_window_end_R2: assert property (@(posedge ref_clk) disable iff (!rst_n)
      !eval_r |=> $stable(in_lock));

endmodule

// File: tb/refclk_lock_monitor_test.sv
module refclk_lock_monitor_test;
   timeunit 1ns;
   timeprecision 1fs;

   localparam real CLK_PERIOD_NS = 1.0;
   localparam int  W    = 9;
   localparam int  PL   = 1000;
   localparam int  PK   = 500;
   localparam int  NWIN = 1 << W;

   logic       ref_clk   = 1'b0;
   logic       word_clk  = 1'b0;
   logic       rst_n     = 1'b0;
   logic [1:0] ratio_sel = 2'd3;
   logic       in_lock;

   bit  word_run = 1'b1;
   real ref_half = 8.0;
   int  n_checks = 0;
   int  n_fail   = 0;

   refclk_lock_monitor #(
      .WIN_LOG2 (W),
      .PPM_LOSS (PL),
      .PPM_LOCK (PK),
      .SYNC_STAGES (2)
   ) uut (
      .ref_clk   (ref_clk),
      .word_clk  (word_clk),
      .rst_n     (rst_n),
      .ratio_sel (ratio_sel),
      .in_lock   (in_lock)
   );

   initial forever begin
      #(CLK_PERIOD_NS / 2.0);
      if (word_run) word_clk = ~word_clk;
   end

   initial begin
      #0.237;
      forever begin
         #(ref_half);
         ref_clk = ~ref_clk;
      end
   end

   // model of the select encoding (R3) and thresholds (R4, R5)
   function automatic int shift_of(input logic [1:0] s);
      case (s)
         2'd0:    return 0;
         2'd1:    return 2;
         2'd2:    return 3;
         default: return 4;
      endcase
   endfunction

   function automatic longint expect_of(input logic [1:0] s);
      return longint'(1) << (W + shift_of(s));
   endfunction

   function automatic longint loss_of(input logic [1:0] s);
      return (longint'(PL) * expect_of(s)) / 1000000;
   endfunction

   function automatic longint lock_of(input logic [1:0] s);
      return (longint'(PK) * expect_of(s) - 1) / 1000000;
   endfunction

   // 0 = unlocked, 1 = locked, -1 = too close to a limit to predict
   function automatic int predict(input int prev, input int ppm, input logic [1:0] s);
      real d;
      if (ppm == 0) return 1;
      d = real'(expect_of(s)) * real'(ppm) / 1.0e6;
      if (d < 0.0) d = -d;
      if (d > real'(loss_of(s)) + 1.4) return 0;
      if (d < real'(lock_of(s)) - 0.4) return 1;
      if (d > real'(lock_of(s)) + 1.4 && d < real'(loss_of(s)) - 0.4) return prev;
      return -1;
   endfunction

   task automatic set_ppm(input int ppm);
      ref_half = real'(1 << shift_of(ratio_sel)) * CLK_PERIOD_NS / 2.0 * (1.0 + real'(ppm) * 1.0e-6);
   endtask

   task automatic next_window();
      repeat (NWIN) @(posedge ref_clk);
      #0.25;
   endtask

   task automatic check(input string req, input logic expv);
      n_checks++;
      if (in_lock !== expv) begin
         n_fail++;
         $display("FAIL %s sel=%0d in_lock=%b expected %b", req, ratio_sel, in_lock, expv);
      end
   endtask

   task automatic start_group(input logic [1:0] s, input int ppm);
      rst_n     = 1'b0;
      word_run  = 1'b1;
      ratio_sel = s;
      set_ppm(ppm);
      repeat (3) @(posedge ref_clk);
      #0.25;
      check("R1 in reset", 1'b0);
      @(negedge ref_clk);
      rst_n = 1'b1;
      next_window();
      check("R1 baseline window", 1'b0);
      next_window();
      check("R3 first verdict matched ratio", 1'b1);
   endtask

   task automatic finish_run();
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   endtask

   initial begin
      #(180000.0 * CLK_PERIOD_NS);
      n_checks++;
      n_fail++;
      $display("FAIL R2 watchdog: in_lock=%b expected run completion", in_lock);
      finish_run();
   end

   initial begin
      int prev;
      void'($urandom(32'd7321));

      // ratio 1/16: hysteresis and random deviations
      start_group(2'd3, 0);
      set_ppm(750);   next_window(); check("R6 band keeps lock", 1'b1);
      set_ppm(2000);  next_window(); check("R4 large deviation", 1'b0);
      set_ppm(750);   next_window(); check("R6 band keeps loss", 1'b0);
      set_ppm(-200);  next_window(); check("R5 relock fast ref", 1'b1);
      prev = 1;
      for (int i = 0; i < 4; i++) begin
         int p;
         int e;
         do begin
            p = int'($urandom_range(6000)) - 3000;
            e = predict(prev, p, ratio_sel);
         end while (e < 0);
         set_ppm(p);
         next_window();
         if (p < 0)       check("R7 random fast ref", e[0]);
         else if (e == 0) check("R4 random", 1'b0);
         else             check("R5/R6 random", e[0]);
         prev = e;
      end

      // ratio 1: equal rates
      start_group(2'd0, 0);
      set_ppm(5000);  next_window(); check("R4 equal-rate mismatch", 1'b0);

      // ratio 1/4: negative deviation and stalled word clock
      start_group(2'd1, 0);
      set_ppm(-3000); next_window(); check("R7 fast ref loss", 1'b0);
      set_ppm(0);     next_window(); check("R5 relock", 1'b1);
      word_run = 1'b0; next_window(); check("R8 stalled word clock", 1'b0);
      word_run = 1'b1; next_window();
      next_window(); check("R8 recovery", 1'b1);

      // ratio 1/8
      start_group(2'd2, 0);
      set_ppm(2500);  next_window(); check("R4 slow ref loss", 1'b0);
      set_ppm(-100);  next_window(); check("R5 small deviation", 1'b1);

      finish_run();
   end

endmodule